// File: doc/BRIEF.md
# Sleep GPIO Edge Wake-Up Controller

This block chooses which edges on sixteen general-purpose inputs may bring the chip out of sleep. Software programs three 32-bit enable registers over a simple register port: a per-pin wake enable, a per-pin rising-edge enable and a per-pin falling-edge enable. While the sleep indication is high, each synchronised pin is watched for edges. An edge raises a sticky wake request only when the pin is enabled and that edge direction is also enabled for it. The request stays high until a dedicated acknowledge clears it.

The block also has a safety fallback. A falling transition on either active-low supply or battery fault input rewrites the falling-edge enable register so that only the falling edges of pins 0 and 1 remain armed. Software can block this fault override with a lock bit in the wake enable register. A hardware reset, a watchdog reset pulse or a GPIO reset pulse always performs the same rewrite.

Top module: `gpio_wake_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the wake enable register, the lock bit and the rising-edge enable register clear to zero. The falling-edge enable register loads 0x0000_0003, and `wake_req` goes low.
- R2: `reg_sel` chooses a register: 0 is the wake enable, 1 is the rising-edge enable, 2 is the falling-edge enable, and 3 reads zero and ignores writes. For each register, bits [15:0] are the per-pin enables. Bit 31 of the wake enable register is the fault-override lock. Every other bit reads back as zero.
- R3: While asleep, a high-to-low change on pin n sets `wake_req` only if bit n is set in both the wake enable register and the falling-edge enable register.
- R4: While asleep, a low-to-high change on pin n sets `wake_req` only if bit n is set in both the wake enable register and the rising-edge enable register.
- R5: Pin edges that occur while `sleep_active` is low never set `wake_req`, including after sleep is entered later.
- R6: Once set, `wake_req` stays high until `wake_ack` is asserted. An asserted `wake_ack` clears it on the next edge, unless a new qualifying edge arrives in that same cycle.
- R7: With the lock bit at 0, a high-to-low transition on `vdd_fault_n` or `batt_fault_n` loads the falling-edge enable register with 0x0000_0003 within five clock cycles. The other registers are left unchanged.
- R8: With the lock bit at 1, fault input transitions leave the falling-edge enable register unchanged.
- R9: A one-cycle pulse on `wdt_rst` or on `gpio_rst` loads the falling-edge enable register with 0x0000_0003.
- R10: When a load from a fault, a watchdog pulse or a GPIO reset pulse falls in the same cycle as a software write to the falling-edge enable register, the load wins.
- R11: A fault input held low triggers the override only once. A later software write to the falling-edge enable register sticks while the fault is still asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| wdt_rst | input | 1 | Watchdog reset pulse, synchronous to clk |
| gpio_rst | input | 1 | GPIO reset pulse, synchronous to clk |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register (combinational) |
| gpio_in | input | 16 | Asynchronous GPIO pin levels |
| sleep_active | input | 1 | High while the chip is asleep |
| vdd_fault_n | input | 1 | Asynchronous active-low supply fault |
| batt_fault_n | input | 1 | Asynchronous active-low battery fault |
| wake_ack | input | 1 | Clears the wake request |
| wake_req | output | 1 | Sticky wake request |

## Verification
The hardest situation to reach from the ports is a load of the falling-edge register that lands in the same clock cycle as a software write to it. The fault path passes through synchronisers, so its timing is hard to line up with a write. The stimulus therefore raises the watchdog pulse and the write strobe in the same cycle, since both share the same load path. A held fault followed by a rewrite covers the case where the override fires only once. Edges made while awake are followed by entry into sleep, to show that no stale edge leaks through.

// File: rtl/gwk_pkg.sv
package gwk_pkg;
    // Register select encodings seen on the register port
    typedef enum logic [1:0] {
        SEL_PIN  = 2'd0,
        SEL_RISE = 2'd1,
        SEL_FALL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gwk_sync.sv
// Two-flop synchroniser for a bus of independent asynchronous bits.
// Assumes each bit is sampled on its own; no bus coherence is implied.
module gwk_sync #(
    parameter int unsigned WIDTH = 1,
    parameter logic [WIDTH-1:0] IDLE = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta;

    // Two-stage resample into the clk domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= IDLE;
            q    <= IDLE;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/gwk_fault_trig.sv
// Turns the active-low fault inputs into a one-cycle trigger per assertion.
// Assumes the inputs are asynchronous and idle high.
module gwk_fault_trig #(
    parameter int unsigned SRC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] fault_n,
    output logic             trig
);
    logic [SRC_N-1:0] level;
    logic [SRC_N-1:0] level_d;
    logic [SRC_N-1:0] fell;

    gwk_sync #(.WIDTH(SRC_N), .IDLE({SRC_N{1'b1}})) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (fault_n),
        .q    (level)
    );

    // Remember the previous synchronised level of every source
    always_ff @(posedge clk) begin
        if (!rst_n) level_d <= {SRC_N{1'b1}};
        else        level_d <= level;
    end

    // Per-source high-to-low detection
    always_comb begin
        fell = level_d & ~level;
        trig = |fell;
    end
endmodule

// File: rtl/gwk_regs.sv
// Holds the wake, rising and falling enable registers plus the fault lock.
// Assumes arm_fall is already qualified; arm_fall beats a same-cycle write.
module gwk_regs
    import gwk_pkg::*;
#(
    parameter int unsigned PINS     = 16,
    parameter int unsigned DATA_W   = 32,
    parameter logic [PINS-1:0] FALL_ARM = 'h3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              arm_fall,
    output logic [PINS-1:0]   pin_en,
    output logic              lock,
    output logic [PINS-1:0]   rise_en,
    output logic [PINS-1:0]   fall_en,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned LOCK_POS = DATA_W - 1;

    reg_sel_e sel_e;
    logic     unused_rsvd;

    assign sel_e       = reg_sel_e'(sel);
    assign unused_rsvd = ^wdata[DATA_W-2:PINS];

    // Wake enable bits and lock bit, software-owned
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_en <= '0;
            lock   <= 1'b0;
        end else if (wr && sel_e == SEL_PIN) begin
            pin_en <= wdata[PINS-1:0];
            lock   <= wdata[LOCK_POS];
        end
    end

    // Rising-edge enable bits, software-owned
    always_ff @(posedge clk) begin
        if (!rst_n)                        rise_en <= '0;
        else if (wr && sel_e == SEL_RISE)  rise_en <= wdata[PINS-1:0];
    end

    // Falling-edge enable bits; a forced load wins over software
    always_ff @(posedge clk) begin
        if (!rst_n)                        fall_en <= FALL_ARM;
        else if (arm_fall)                 fall_en <= FALL_ARM;
        else if (wr && sel_e == SEL_FALL)  fall_en <= wdata[PINS-1:0];
    end

    // Read mux; reserved bits read zero
    always_comb begin
        rdata = '0;
        unique case (sel_e)
            SEL_PIN: begin
                rdata[PINS-1:0] = pin_en;
                rdata[LOCK_POS] = lock;
            end
            SEL_RISE: rdata[PINS-1:0] = rise_en;
            SEL_FALL: rdata[PINS-1:0] = fall_en;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/gwk_edge.sv
// Synchronises pins, detects edges during sleep and keeps a sticky request.
// Assumes edges seen while awake are discarded, not queued.
module gwk_edge #(
    parameter int unsigned PINS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pins,
    input  logic            sleep,
    input  logic [PINS-1:0] pin_en,
    input  logic [PINS-1:0] rise_en,
    input  logic [PINS-1:0] fall_en,
    input  logic            ack,
    output logic            wake_req
);
    logic [PINS-1:0] now;
    logic [PINS-1:0] last;
    logic [PINS-1:0] hit;
    logic            any_hit;

    gwk_sync #(.WIDTH(PINS), .IDLE('0)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pins),
        .q    (now)
    );

    // Previous synchronised sample; tracks even while awake
    always_ff @(posedge clk) begin
        if (!rst_n) last <= '0;
        else        last <= now;
    end

    // Per-pin qualification of each edge direction
    for (genvar i = 0; i < PINS; i++) begin : g_pin
        always_comb begin
            hit[i] = pin_en[i] & ((rise_en[i] & now[i] & ~last[i]) |
                                  (fall_en[i] & ~now[i] & last[i]));
        end
    end

    assign any_hit = sleep & (|hit);

    // Sticky request; a fresh hit wins over acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)       wake_req <= 1'b0;
        else if (any_hit) wake_req <= 1'b1;
        else if (ack)     wake_req <= 1'b0;
    end
endmodule

// File: rtl/gpio_wake_ctrl.sv
// Top of the sleep GPIO wake-up controller.
// Assumes wdt_rst and gpio_rst are single-cycle pulses synchronous to clk.
module gpio_wake_ctrl #(
    parameter int unsigned PINS   = 16,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wdt_rst,
    input  logic              gpio_rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [PINS-1:0]   gpio_in,
    input  logic              sleep_active,
    input  logic              vdd_fault_n,
    input  logic              batt_fault_n,
    input  logic              wake_ack,
    output logic              wake_req
);
    localparam logic [PINS-1:0] FALL_ARM = PINS'(3);

    logic [PINS-1:0] pin_en;
    logic [PINS-1:0] rise_en;
    logic [PINS-1:0] fall_en;
    logic            fault_lock;
    logic            fault_trig;
    logic            arm_fall;

    gwk_fault_trig #(.SRC_N(2)) u_fault (
        .clk    (clk),
        .rst_n  (rst_n),
        .fault_n({batt_fault_n, vdd_fault_n}),
        .trig   (fault_trig)
    );

    // Forced falling-edge load: unlocked fault, watchdog or GPIO reset
    assign arm_fall = (fault_trig & ~fault_lock) | wdt_rst | gpio_rst;

    gwk_regs #(.PINS(PINS), .DATA_W(DATA_W), .FALL_ARM(FALL_ARM)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .sel     (reg_sel),
        .wdata   (reg_wdata),
        .arm_fall(arm_fall),
        .pin_en  (pin_en),
        .lock    (fault_lock),
        .rise_en (rise_en),
        .fall_en (fall_en),
        .rdata   (reg_rdata)
    );

    gwk_edge #(.PINS(PINS)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .pins    (gpio_in),
        .sleep   (sleep_active),
        .pin_en  (pin_en),
        .rise_en (rise_en),
        .fall_en (fall_en),
        .ack     (wake_ack),
        .wake_req(wake_req)
    );
endmodule

// File: rtl/gwk_checker.sv
// Property checker for gpio_wake_ctrl, attached by bind.
module gwk_checker #(
    parameter int unsigned PINS   = 16,
    parameter int unsigned DATA_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wdt_rst,
    input logic               gpio_rst,
    input logic               reg_wr,
    input logic [1:0]         reg_sel,
    input logic [DATA_W-PINS-1:0] rdata_hi,
    input logic               sleep_active,
    input logic               wake_ack,
    input logic               wake_req,
    input logic [PINS-1:0]    fall_en,
    input logic               fault_lock
);
    // R1: reset arms pins 0 and 1 for falling edges and drops the request
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (fall_en == PINS'(3)) && !wake_req);

    // R2: reserved high bits read zero outside the wake register
    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel != 2'd0) |-> (rdata_hi == '0));

    // R5: a request only rises after a sleeping cycle
    assert_sleep_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_req) |-> $past(sleep_active));

    // R6: request holds without acknowledge
    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req && !wake_ack) |=> wake_req);

    // R6: acknowledge while awake clears the request
    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_ack && !sleep_active) |=> !wake_req);

    // R8: with lock set, only writes or reset pulses change the falling register
    assert_lock_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_lock && !wdt_rst && !gpio_rst && !(reg_wr && reg_sel == 2'd2))
        |=> $stable(fall_en));

    // R9: watchdog or GPIO reset pulse forces the falling arm value
    assert_pulse_loads_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_rst || gpio_rst) |=> (fall_en == PINS'(3)));
endmodule

bind gpio_wake_ctrl gwk_checker #(.PINS(PINS), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wdt_rst     (wdt_rst),
    .gpio_rst    (gpio_rst),
    .reg_wr      (reg_wr),
    .reg_sel     (reg_sel),
    .rdata_hi    (reg_rdata[DATA_W-1:PINS]),
    .sleep_active(sleep_active),
    .wake_ack    (wake_ack),
    .wake_req    (wake_req),
    .fall_en     (fall_en),
    .fault_lock  (fault_lock)
);

// File: tb/gpio_wake_ctrl_test.sv
module gpio_wake_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wdt_rst = 1'b0;
    logic        gpio_rst = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] gpio_in = '0;
    logic        sleep_active = 1'b0;
    logic        vdd_fault_n = 1'b1;
    logic        batt_fault_n = 1'b1;
    logic        wake_ack = 1'b0;
    logic        wake_req;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
        bit          wk;
    } item_t;
    item_t exp_q[$];

    always #5 clk = ~clk;

    gpio_wake_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wdt_rst(wdt_rst), .gpio_rst(gpio_rst),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .gpio_in(gpio_in), .sleep_active(sleep_active),
        .vdd_fault_n(vdd_fault_n), .batt_fault_n(batt_fault_n),
        .wake_ack(wake_ack), .wake_req(wake_req)
    );

    // Monitor: compares queued expectations at the falling edge
    initial begin
        item_t       it;
        logic [31:0] act;
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0) begin
                it  = exp_q.pop_front();
                act = it.wk ? {31'b0, wake_req} : reg_rdata;
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic expect_reg(input logic [1:0] s, input logic [31:0] e, input string tag);
        @(posedge clk); #1;
        reg_sel = s;
        exp_q.push_back('{exp: e, tag: tag, wk: 1'b0});
        @(negedge clk); #1;
    endtask

    task automatic expect_wake(input logic e, input string tag);
        @(posedge clk); #1;
        exp_q.push_back('{exp: {31'b0, e}, tag: tag, wk: 1'b1});
        @(negedge clk); #1;
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic pins(input logic [15:0] v);
        @(posedge clk); #1;
        gpio_in = v;
        repeat (4) @(posedge clk);
    endtask

    task automatic ack();
        @(posedge clk); #1;
        wake_ack = 1'b1;
        @(posedge clk); #1;
        wake_ack = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        expect_reg(2'd0, 32'h0, "R1 wake reg");
        expect_reg(2'd1, 32'h0, "R1 rise reg");
        expect_reg(2'd2, 32'h3, "R1 fall reg");
        expect_wake(1'b0, "R1 wake_req");

        // R2: read/write and reserved bits
        wr(2'd0, 32'hFFFF_FFFF);
        expect_reg(2'd0, 32'h8000_FFFF, "R2 wake reg reserved");
        wr(2'd1, 32'hFFFF_FFFF);
        expect_reg(2'd1, 32'h0000_FFFF, "R2 rise reg reserved");
        wr(2'd3, 32'h1234_5678);
        expect_reg(2'd3, 32'h0, "R2 unused select");
        wr(2'd0, 32'h0000_0010);
        wr(2'd1, 32'h0);
        wr(2'd2, 32'h0000_0030);

        // R4 negative then R3 positive on pin 4
        @(posedge clk); #1 sleep_active = 1'b1;
        pins(16'h0010);
        expect_wake(1'b0, "R4 rise without rise enable");
        pins(16'h0000);
        expect_wake(1'b1, "R3 falling edge wakes");
        wait_cyc(5);
        expect_wake(1'b1, "R6 request sticky");
        ack();
        expect_wake(1'b0, "R6 ack clears");

        // R3 negative: pin 5 falling enabled but pin wake disabled
        pins(16'h0020);
        pins(16'h0000);
        expect_wake(1'b0, "R3 pin wake bit clear");

        // R4 positive
        wr(2'd1, 32'h0000_0010);
        pins(16'h0010);
        expect_wake(1'b1, "R4 rising edge wakes");
        ack();
        expect_wake(1'b0, "R6 ack after rise");

        // R5: edges while awake
        @(posedge clk); #1 sleep_active = 1'b0;
        pins(16'h0000);
        pins(16'h0010);
        expect_wake(1'b0, "R5 awake edges ignored");
        @(posedge clk); #1 sleep_active = 1'b1;
        wait_cyc(4);
        expect_wake(1'b0, "R5 no stale edge on sleep entry");

        // R7: unlocked supply fault
        wr(2'd2, 32'h0000_00F0);
        @(posedge clk); #1 vdd_fault_n = 1'b0;
        wait_cyc(5);
        expect_reg(2'd2, 32'h3, "R7 supply fault loads fall");
        expect_reg(2'd1, 32'h0000_0010, "R7 rise reg untouched");

        // R11: held fault fires once
        wr(2'd2, 32'h0000_00F0);
        wait_cyc(6);
        expect_reg(2'd2, 32'h0000_00F0, "R11 held fault no refire");
        @(posedge clk); #1 vdd_fault_n = 1'b1;
        wait_cyc(4);

        // R7: unlocked battery fault
        @(posedge clk); #1 batt_fault_n = 1'b0;
        wait_cyc(5);
        expect_reg(2'd2, 32'h3, "R7 battery fault loads fall");
        @(posedge clk); #1 batt_fault_n = 1'b1;
        wait_cyc(4);

        // R8: locked fault has no effect
        wr(2'd2, 32'h0000_00F0);
        wr(2'd0, 32'h8000_0010);
        @(posedge clk); #1 batt_fault_n = 1'b0;
        wait_cyc(6);
        expect_reg(2'd2, 32'h0000_00F0, "R8 lock blocks fault");
        @(posedge clk); #1 batt_fault_n = 1'b1;
        wait_cyc(4);
        wr(2'd0, 32'h0000_0010);

        // R9: watchdog and GPIO reset pulses
        @(posedge clk); #1 wdt_rst = 1'b1;
        @(posedge clk); #1 wdt_rst = 1'b0;
        expect_reg(2'd2, 32'h3, "R9 watchdog pulse");
        wr(2'd2, 32'h0000_00F0);
        @(posedge clk); #1 gpio_rst = 1'b1;
        @(posedge clk); #1 gpio_rst = 1'b0;
        expect_reg(2'd2, 32'h3, "R9 gpio reset pulse");

        // R10: forced load beats same-cycle write
        wr(2'd2, 32'h0000_00F0);
        @(posedge clk); #1;
        wdt_rst = 1'b1; reg_wr = 1'b1; reg_sel = 2'd2; reg_wdata = 32'h0000_00C0;
        @(posedge clk); #1;
        wdt_rst = 1'b0; reg_wr = 1'b0;
        expect_reg(2'd2, 32'h3, "R10 load beats write");

        @(negedge clk); @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog R1..: actual hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule